// File: doc/BRIEF.md
# Reset Cause Recorder and Reset Pulse Generator

This block merges three reasons to reset a chip into one synchronous system reset: a digital power-on indication, an active-low reset pin from outside the chip, and a request written by software. The pin is brought into the clock domain through a synchronizer. It then has to stay low for a programmable number of cycles before it counts as a request. Shorter low pulses are dropped and leave a sticky flag behind.

The reset output stays high while any request is present and for a fixed number of cycles after the last one goes away. A small register file records which source caused the most recent reset. When sources overlap, only the highest-priority source is recorded. The register file also holds the software trigger and the filter length. Software reads it after reset ends and clears bits by writing ones to them.

Top module: `rst_cause_unit`

## Requirements
- R1: While `por_i` is high at a clock edge, `sys_rst_o` is 1 after that edge. The status register (address 0) is forced to 0x1, with only the power-on bit (bit 0) set and the glitch flag cleared. The filter length (address 2) returns to 16.
- R2: After the synchronizer, the pin counts as a reset request only once it has been low for at least the filter length of cycles. With a length of L, a pin driven low just after edge 0 and held low raises `sys_rst_o` after edge L+3 and not before. The recorded cause is then 0x2 (bit 1).
- R3: A low pulse on the pin that is shorter than the filter length produces no reset. It sets the glitch flag (status bit 3) and leaves the cause bits unchanged. With length 16, pulses of 15 and 5 cycles are both rejected.
- R4: Writing 1 to bit 0 of the control register (address 1) is a one-shot software request. If the write is sampled at edge 1, `sys_rst_o` is 1 after edge 2 and the cause is 0x4 (bit 2).
- R5: `sys_rst_o` stays 1 for 32 cycles after the last edge at which a request was sampled, and is 0 from the 33rd edge after it onward.
- R6: When sources are active together, power-on beats the pin and the pin beats software. Only the winner's bit is set, so at most one cause bit is ever set.
- R7: A write to the status register clears exactly the bits written as 1. The glitch flag stays set until it is cleared this way or by power-on.
- R8: The filter length is read and written at address 2 (8 bits). A value of 0 acts as 1.
- R9: A pin or software reset replaces only the cause bits. It keeps the glitch flag and the filter length.
- R10: A read returns its data one cycle after the address is sampled. The control register and address 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on indication, active high, synchronous; also clears the block |
| ext_rst_n_i | input | 1 | Reset pin from outside, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, registered |
| sys_rst_o | output | 1 | Stretched system reset, active high |

## Verification
Every result has a fixed delay that follows from the register stages in its path. A pin reset appears L+3 edges after the pin falls: two synchronizer stages, L filter samples and the output flop. A software reset appears two edges after the write is sampled. The output falls 33 edges after the last sampled request, and read data appears one edge after the address. The bench drives all inputs one time step after a rising edge and counts edges explicitly. At each of these boundaries it samples both the last cycle before the change and the first cycle after it. Rejected pulses are checked on every cycle of a window that extends well past the point where an accepted pulse would have raised the output.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  // Register addresses
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] RA_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] RA_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] RA_FILT   = 2'd2;

  // Status layout: cause bits are one-hot, the glitch flag is sticky
  localparam int ST_W      = 4;
  localparam int ST_POR    = 0;
  localparam int ST_PIN    = 1;
  localparam int ST_SW     = 2;
  localparam int ST_GLITCH = 3;

  localparam logic [ST_W-1:0] CAUSE_MASK = 4'b0111;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_POR  = 2'd1,
    SRC_PIN  = 2'd2,
    SRC_SW   = 2'd3
  } src_e;

  // Fixed priority: power-on, then pin, then software
  function automatic src_e pick_source(input logic por, input logic pin, input logic sw);
    if (por)      return SRC_POR;
    else if (pin) return SRC_PIN;
    else if (sw)  return SRC_SW;
    else          return SRC_NONE;
  endfunction

  function automatic logic [ST_W-1:0] cause_bits(input src_e src);
    logic [ST_W-1:0] v;
    v = '0;
    case (src)
      SRC_POR: v[ST_POR] = 1'b1;
      SRC_PIN: v[ST_PIN] = 1'b1;
      SRC_SW:  v[ST_SW]  = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rcu_pin_filter.sv
// Synchronizes the active-low pin, then accepts it only after a run of low samples.
module rcu_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             pin_n,
  input  logic [CNT_W-1:0] len,
  output logic             req_o,
  output logic             glitch_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       len_eff;
  logic                   low;

  always_ff @(posedge clk) begin
    if (clr) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
  end

  assign low     = ~sync_q[SYNC_STAGES-1];
  assign len_eff = (len == '0) ? ONE : len;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q    <= '0;
      req_o    <= 1'b0;
      glitch_o <= 1'b0;
    end else if (low) begin
      if (cnt_q < len_eff) cnt_q <= cnt_q + ONE;
      req_o    <= (cnt_q >= (len_eff - ONE));
      glitch_o <= 1'b0;
    end else begin
      cnt_q    <= '0;
      req_o    <= 1'b0;
      glitch_o <= (cnt_q != '0) && (cnt_q < len_eff);
    end
  end

endmodule

// File: rtl/rcu_stretch.sv
// Holds the reset output for HOLD cycles after the last request.
module rcu_stretch #(
  parameter int HOLD = 32
) (
  input  logic clk,
  input  logic req,
  output logic rst_o
);

  localparam int HOLD_W = $clog2(HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_V = HOLD_W'(HOLD);
  localparam logic [HOLD_W-1:0] ONE    = HOLD_W'(1);

  logic [HOLD_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (req) begin
      left_q <= HOLD_V;
      rst_o  <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - ONE;
      rst_o  <= 1'b1;
    end else begin
      rst_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/rcu_regs.sv
// Status, control and filter-length registers with registered read data.
module rcu_regs
  import rcu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FILT_W     = 8,
  parameter int FILT_RESET = 16
) (
  input  logic              clk,
  input  logic              por,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pin_req,
  input  logic              glitch,
  output logic              sw_req_o,
  output logic [FILT_W-1:0] filt_len_o,
  output logic [ST_W-1:0]   status_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ST_W-1:0] status_d;
  src_e            winner;

  assign winner = pick_source(1'b0, pin_req, sw_req_o);

  always_comb begin
    status_d = status_o;
    if (we && addr == RA_STATUS) status_d = status_d & ~wdata[ST_W-1:0];
    if (glitch) status_d[ST_GLITCH] = 1'b1;
    if (winner != SRC_NONE)
      status_d = (status_d & ~CAUSE_MASK) | cause_bits(winner);
  end

  always_ff @(posedge clk) begin
    if (por) begin
      status_o   <= cause_bits(SRC_POR);
      sw_req_o   <= 1'b0;
      filt_len_o <= FILT_W'(FILT_RESET);
      rdata_o    <= '0;
    end else begin
      status_o <= status_d;
      sw_req_o <= we && (addr == RA_CTRL) && wdata[0];
      if (we && addr == RA_FILT) filt_len_o <= wdata[FILT_W-1:0];
      case (addr)
        RA_STATUS: rdata_o <= DATA_W'(status_o);
        RA_FILT:   rdata_o <= DATA_W'(filt_len_o);
        default:   rdata_o <= '0;
      endcase
    end
  end

endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
  import rcu_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 8,
  parameter int FILT_RESET  = 16,
  parameter int HOLD        = 32,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              ext_rst_n_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sys_rst_o
);

  logic              pin_req;
  logic              glitch;
  logic              sw_req;
  logic              req_any;
  logic [FILT_W-1:0] filt_len;
  logic [ST_W-1:0]   status_w;

  rcu_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(FILT_W)) u_filt (
    .clk     (clk),
    .clr     (por_i),
    .pin_n   (ext_rst_n_i),
    .len     (filt_len),
    .req_o   (pin_req),
    .glitch_o(glitch)
  );

  rcu_regs #(.DATA_W(DATA_W), .FILT_W(FILT_W), .FILT_RESET(FILT_RESET)) u_regs (
    .clk       (clk),
    .por       (por_i),
    .we        (reg_we_i),
    .addr      (reg_addr_i),
    .wdata     (reg_wdata_i),
    .pin_req   (pin_req),
    .glitch    (glitch),
    .sw_req_o  (sw_req),
    .filt_len_o(filt_len),
    .status_o  (status_w),
    .rdata_o   (reg_rdata_o)
  );

  assign req_any = por_i | pin_req | sw_req;

  rcu_stretch #(.HOLD(HOLD)) u_hold (
    .clk  (clk),
    .req  (req_any),
    .rst_o(sys_rst_o)
  );

endmodule

// File: rtl/rst_cause_unit_chk.sv
module rst_cause_unit_chk #(
  parameter int HOLD   = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              por_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              req_any,
  input logic [3:0]        status,
  input logic              sys_rst_o
);

  localparam int REL_W = $clog2(HOLD + 2);
  localparam logic [REL_W-1:0] HOLD_V = REL_W'(HOLD);

  logic             armed_q  = 1'b0;
  logic             armed2_q = 1'b0;
  logic [REL_W-1:0] rel_q    = '0;

  always_ff @(posedge clk) begin
    armed_q  <= armed_q | por_i;
    armed2_q <= armed_q;
    if (req_any)              rel_q <= '0;
    else if (rel_q <= HOLD_V) rel_q <= rel_q + REL_W'(1);
  end

  assert_por_reset_R1: assert property (@(posedge clk) disable iff (!armed_q)
    por_i |=> sys_rst_o);

  assert_por_status_R1: assert property (@(posedge clk) disable iff (!armed_q)
    por_i |=> (status == 4'b0001));

  assert_sw_reset_R4: assert property (@(posedge clk) disable iff (por_i || !armed2_q)
    (reg_we_i && reg_addr_i == 2'd1 && reg_wdata_i[0]) |=> ##1 sys_rst_o);

  assert_hold_high_R5: assert property (@(posedge clk) disable iff (!armed2_q)
    (rel_q <= HOLD_V) |-> sys_rst_o);

  assert_release_low_R5: assert property (@(posedge clk) disable iff (!armed2_q)
    (rel_q > HOLD_V) |-> !sys_rst_o);

  assert_cause_onehot_R6: assert property (@(posedge clk) disable iff (!armed2_q)
    $onehot0(status[2:0]));

  assert_glitch_sticky_R7: assert property (@(posedge clk) disable iff (!armed2_q)
    $fell(status[3]) |-> ($past(por_i) || $past(reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i[3])));

endmodule

bind rst_cause_unit rst_cause_unit_chk #(.HOLD(HOLD), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .por_i      (por_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .req_any    (req_any),
  .status     (status_w),
  .sys_rst_o  (sys_rst_o)
);

// File: tb/tb_rst_cause_unit.sv
`timescale 1ns/1ps
module tb_rst_cause_unit;

  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       ext_rst_n_i = 1'b1;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic       sys_rst_o;

  int checks = 0;
  int fails  = 0;

  rst_cause_unit dut (
    .clk        (clk),
    .por_i      (por_i),
    .ext_rst_n_i(ext_rst_n_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .sys_rst_o  (sys_rst_o)
  );

  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_we_i = 1'b0; reg_wdata_i = 8'd0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    step();
    d = reg_rdata_o;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input int exp);
    logic [7:0] d;
    reg_read(a, d);
    check(req, $sformatf("read addr %0d", a), int'(d), exp);
  endtask

  // Low pulse of p cycles, then q cycles idle; output must never rise
  task automatic quiet_pulse(input string req, input int p, input int q);
    int bad = 0;
    ext_rst_n_i = 1'b0;
    for (int i = 0; i < p; i++) begin step(); if (sys_rst_o) bad++; end
    ext_rst_n_i = 1'b1;
    for (int i = 0; i < q; i++) begin step(); if (sys_rst_o) bad++; end
    check(req, $sformatf("no reset for %0d-cycle pulse (high cycles)", p), bad, 0);
  endtask

  task automatic t_power_on();
    steps(4);
    check("R1", "sys_rst during power-on", int'(sys_rst_o), 1);
    por_i = 1'b0;                           // last por sampled at edge 4
    expect_reg("R1", 2'd0, 8'h01);          // edge 5
    expect_reg("R1", 2'd2, 16);             // edge 6, filter length default
    expect_reg("R10", 2'd1, 0);             // edge 7, control reads 0
    expect_reg("R10", 2'd3, 0);             // edge 8, spare address
    steps(28);                              // edge 36
    check("R5", "held 32 cycles after power-on", int'(sys_rst_o), 1);
    step();                                 // edge 37
    check("R5", "released after power-on hold", int'(sys_rst_o), 0);
  endtask

  task automatic t_pin_accept();
    ext_rst_n_i = 1'b0;                     // after edge 0
    steps(18);
    check("R2", "no reset before L+3", int'(sys_rst_o), 0);
    step();                                 // edge 19
    check("R2", "reset at L+3", int'(sys_rst_o), 1);
    steps(6);
    ext_rst_n_i = 1'b1;                     // after edge R0; last request at R3
    steps(35);
    check("R5", "held after pin release", int'(sys_rst_o), 1);
    step();
    check("R5", "released 33 edges after last pin request", int'(sys_rst_o), 0);
    expect_reg("R2", 2'd0, 8'h02);
  endtask

  task automatic t_glitch();
    reg_write(2'd0, 8'h0F);
    expect_reg("R7", 2'd0, 8'h00);
    quiet_pulse("R3", 15, 40);
    expect_reg("R3", 2'd0, 8'h08);
    quiet_pulse("R3", 5, 40);
    expect_reg("R3", 2'd0, 8'h08);
  endtask

  task automatic t_clear();
    reg_write(2'd0, 8'h00);
    expect_reg("R7", 2'd0, 8'h08);
    reg_write(2'd0, 8'h08);
    expect_reg("R7", 2'd0, 8'h00);
  endtask

  task automatic t_software();
    quiet_pulse("R3", 3, 10);
    reg_write(2'd1, 8'h01);                 // sampled at edge 1
    check("R4", "no reset yet at edge 1", int'(sys_rst_o), 0);
    step();                                 // edge 2
    check("R4", "software reset at edge 2", int'(sys_rst_o), 1);
    steps(32);                              // edge 34
    check("R5", "held after software request", int'(sys_rst_o), 1);
    step();                                 // edge 35
    check("R5", "released after software hold", int'(sys_rst_o), 0);
    expect_reg("R9", 2'd0, 8'h0C);          // glitch kept, cause software
    expect_reg("R9", 2'd2, 16);
  endtask

  task automatic t_priority();
    ext_rst_n_i = 1'b0;
    steps(20);
    reg_write(2'd1, 8'h01);                 // software while pin is active
    steps(3);
    expect_reg("R6", 2'd0, 8'h0A);          // pin wins, glitch kept
    por_i = 1'b1;
    steps(2);
    por_i = 1'b0;
    expect_reg("R6", 2'd0, 8'h01);          // power-on wins and clears glitch
    ext_rst_n_i = 1'b1;
    steps(60);
    check("R5", "idle after priority case", int'(sys_rst_o), 0);
  endtask

  task automatic t_filter_len();
    reg_write(2'd2, 8'd4);
    expect_reg("R8", 2'd2, 4);
    reg_write(2'd0, 8'h0F);
    quiet_pulse("R3", 3, 20);
    expect_reg("R3", 2'd0, 8'h08);
    ext_rst_n_i = 1'b0;
    steps(4);
    ext_rst_n_i = 1'b1;
    steps(2);                               // edge 6
    check("R2", "no reset before L+3 (L=4)", int'(sys_rst_o), 0);
    step();                                 // edge 7
    check("R2", "reset at L+3 (L=4)", int'(sys_rst_o), 1);
    steps(40);
    reg_write(2'd2, 8'd0);
    expect_reg("R8", 2'd2, 0);
    reg_write(2'd0, 8'h0F);
    ext_rst_n_i = 1'b0;
    step();
    ext_rst_n_i = 1'b1;
    steps(2);                               // edge 3
    check("R8", "length 0 acts as 1: not yet", int'(sys_rst_o), 0);
    step();                                 // edge 4
    check("R8", "length 0 acts as 1: reset", int'(sys_rst_o), 1);
    steps(40);
    expect_reg("R8", 2'd0, 8'h02);
  endtask

  initial begin
    t_power_on();
    t_pin_accept();
    t_glitch();
    t_clear();
    t_software();
    t_priority();
    t_filter_len();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule